// File: doc/BRIEF.md
# Dual-Table Register Renamer

This block maps a small set of architectural registers onto a larger pool of physical registers. It keeps two alias tables. The frontend table is updated speculatively each time a micro-op is renamed. The committed table changes only when a result retires. Unused physical tags sit in a free list, which is held as a bitmap. Retirement copies no register data: it only repoints the committed table entry at the physical register that already holds the result. The same physical register therefore stays valid before and after retirement.

Each cycle the block can rename one micro-op with two source registers and one destination register. It returns both physical source tags, the newly allocated destination tag, and the tag the destination mapped to before this rename. A retire port commits one mapping per cycle and releases the tag that mapping displaces. A flush input discards speculative state: in a single cycle, the frontend table is reloaded from the committed table and every tag the committed table does not hold returns to the free list.

Top module: `dual_table_renamer`

## Requirements
- R1: After reset, architectural register i maps to physical tag i in both tables, and tags 8 to 127 are free, so the first allocated tag is 8.
- R2: The source tags and the previous-destination tag are read combinationally from the frontend table. The allocated tag is the lowest-numbered free tag. An accepted rename (valid with ready high) removes that tag from the free list and writes it into the frontend entry of the destination register.
- R3: When one micro-op reads and writes the same register, its source tag is the mapping that existed before this rename.
- R4: `ren_ready` is low when the free list is empty or a flush is requested. A rename offered while ready is low changes neither table nor the free list.
- R5: A retire writes `ret_ptag` into the committed entry of `ret_arch` at the next clock edge and leaves the frontend table unchanged.
- R6: A retire returns the tag previously held in the committed entry of `ret_arch` to the free list, unless that tag equals `ret_ptag`.
- R7: A flush loads the whole frontend table from the committed table in one cycle. It also sets the free list to exactly those tags the committed table does not hold.
- R8: When a retire and a flush occur in the same cycle, the flush copies the committed table with that retire already applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ren_valid | input | 1 | A micro-op is offered for renaming |
| ren_src0 | input | 3 | Architectural index of the first source |
| ren_src1 | input | 3 | Architectural index of the second source |
| ren_dst | input | 3 | Architectural index of the destination |
| ren_ready | output | 1 | Rename can be accepted this cycle |
| ren_psrc0 | output | 7 | Physical tag of the first source |
| ren_psrc1 | output | 7 | Physical tag of the second source |
| ren_pdst | output | 7 | Newly allocated physical tag for the destination |
| ren_pold | output | 7 | Tag the destination mapped to before this rename |
| ret_valid | input | 1 | A mapping is committed this cycle |
| ret_arch | input | 3 | Architectural register being committed |
| ret_ptag | input | 7 | Physical tag that register now commits to |
| flush | input | 1 | Restore the frontend table from the committed table |

## Verification
The assertions check on every cycle that the offered tag is free, that an accepted tag leaves the free list, and that an empty list blocks renaming. They also check that retirement writes only the committed table, that renaming never touches it, and that after a flush the two tables match and exactly 120 tags are free. Some properties depend on the sequence of operations, and only the bench scenarios can show them. These are the lowest-first allocation order, the old tag seen by a micro-op that reads and writes the same register, and a tag displaced at retirement becoming the next allocation. The rest are recovery of the full free pool after running it dry, and the interaction of a retire with a flush in the same cycle.

// File: rtl/dual_table_renamer.sv
module dual_table_renamer #(
  parameter int ARCH_REGS = 8,
  parameter int PHYS_REGS = 128,
  localparam int AW = $clog2(ARCH_REGS),
  localparam int PW = $clog2(PHYS_REGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ren_valid,
  input  logic [AW-1:0] ren_src0,
  input  logic [AW-1:0] ren_src1,
  input  logic [AW-1:0] ren_dst,
  output logic          ren_ready,
  output logic [PW-1:0] ren_psrc0,
  output logic [PW-1:0] ren_psrc1,
  output logic [PW-1:0] ren_pdst,
  output logic [PW-1:0] ren_pold,
  input  logic          ret_valid,
  input  logic [AW-1:0] ret_arch,
  input  logic [PW-1:0] ret_ptag,
  input  logic          flush
);

  logic [PW-1:0]        frat    [ARCH_REGS];
  logic [PW-1:0]        rrat    [ARCH_REGS];
  logic [PW-1:0]        rrat_nx [ARCH_REGS];
  logic [PHYS_REGS-1:0] free_q, free_nx, busy_nx;
  logic [PW-1:0]        alloc_tag, ret_old;
  logic                 have_free, ren_fire, ret_frees;
  logic [ARCH_REGS*PW-1:0] frat_flat, rrat_flat;

  always_comb begin
    alloc_tag = '0;
    have_free = 1'b0;
    for (int i = PHYS_REGS - 1; i >= 0; i--) begin
      if (free_q[i]) begin
        alloc_tag = PW'(i);
        have_free = 1'b1;
      end
    end
  end

  assign ren_ready = have_free & ~flush;
  assign ren_fire  = ren_valid & ren_ready;
  assign ren_psrc0 = frat[ren_src0];
  assign ren_psrc1 = frat[ren_src1];
  assign ren_pold  = frat[ren_dst];
  assign ren_pdst  = alloc_tag;

  assign ret_old   = rrat[ret_arch];
  assign ret_frees = ret_valid && (ret_old != ret_ptag);

  always_comb begin
    for (int a = 0; a < ARCH_REGS; a++) rrat_nx[a] = rrat[a];
    if (ret_valid) rrat_nx[ret_arch] = ret_ptag;
  end

  always_comb begin
    busy_nx = '0;
    for (int a = 0; a < ARCH_REGS; a++) busy_nx[rrat_nx[a]] = 1'b1;
  end

  always_comb begin
    if (flush) begin
      free_nx = ~busy_nx;
    end else begin
      free_nx = free_q;
      if (ren_fire)  free_nx[alloc_tag] = 1'b0;
      if (ret_frees) free_nx[ret_old]   = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int a = 0; a < ARCH_REGS; a++) begin
        frat[a] <= PW'(a);
        rrat[a] <= PW'(a);
      end
      for (int i = 0; i < PHYS_REGS; i++) free_q[i] <= (i >= ARCH_REGS);
    end else begin
      for (int a = 0; a < ARCH_REGS; a++) rrat[a] <= rrat_nx[a];
      if (flush) begin
        for (int a = 0; a < ARCH_REGS; a++) frat[a] <= rrat_nx[a];
      end else if (ren_fire) begin
        frat[ren_dst] <= alloc_tag;
      end
      free_q <= free_nx;
    end
  end

  for (genvar g = 0; g < ARCH_REGS; g++) begin : g_flat
    assign frat_flat[g*PW +: PW] = frat[g];
    assign rrat_flat[g*PW +: PW] = rrat[g];
  end

endmodule

// File: rtl/renamer_checks.sv
module renamer_checks #(
  parameter int ARCH_REGS = 8,
  parameter int PHYS_REGS = 128,
  localparam int AW = $clog2(ARCH_REGS),
  localparam int PW = $clog2(PHYS_REGS)
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    ren_valid,
  input logic                    ren_ready,
  input logic [PW-1:0]           ren_pdst,
  input logic                    ret_valid,
  input logic [AW-1:0]           ret_arch,
  input logic [PW-1:0]           ret_ptag,
  input logic                    flush,
  input logic [PHYS_REGS-1:0]    free_q,
  input logic [ARCH_REGS*PW-1:0] frat_flat,
  input logic [ARCH_REGS*PW-1:0] rrat_flat
);

  p_offer_is_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ren_ready |-> free_q[ren_pdst]);

  p_alloc_taken_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ren_valid && ren_ready) |=> !free_q[$past(ren_pdst)]);

  p_rename_keeps_commit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ret_valid && !flush) |=> $stable(rrat_flat));

  p_empty_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (free_q == '0) |-> !ren_ready);

  p_flush_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !ren_ready);

  p_retire_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid |=> (rrat_flat[$past(ret_arch)*PW +: PW] == $past(ret_ptag)));

  p_retire_keeps_front_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && !flush && !(ren_valid && ren_ready)) |=> $stable(frat_flat));

  p_flush_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (frat_flat == rrat_flat));

  p_flush_pool_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> ($countones(free_q) == PHYS_REGS - ARCH_REGS));

endmodule

bind dual_table_renamer renamer_checks #(.ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS)) u_chk (
  .clk(clk), .rst_n(rst_n), .ren_valid(ren_valid), .ren_ready(ren_ready),
  .ren_pdst(ren_pdst), .ret_valid(ret_valid), .ret_arch(ret_arch),
  .ret_ptag(ret_ptag), .flush(flush), .free_q(free_q),
  .frat_flat(frat_flat), .rrat_flat(rrat_flat)
);

// File: tb/dual_table_renamer_test.sv
module dual_table_renamer_test;
  localparam int CLK_PERIOD = 10;
  localparam int NA = 8;
  localparam int NP = 128;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ren_valid = 1'b0, ret_valid = 1'b0, flush = 1'b0;
  logic [2:0] ren_src0 = '0, ren_src1 = '0, ren_dst = '0, ret_arch = '0;
  logic [6:0] ret_ptag = '0;
  logic ren_ready;
  logic [6:0] ren_psrc0, ren_psrc1, ren_pdst, ren_pold;

  dual_table_renamer uut (
    .clk(clk), .rst_n(rst_n), .ren_valid(ren_valid), .ren_src0(ren_src0),
    .ren_src1(ren_src1), .ren_dst(ren_dst), .ren_ready(ren_ready),
    .ren_psrc0(ren_psrc0), .ren_psrc1(ren_psrc1), .ren_pdst(ren_pdst),
    .ren_pold(ren_pold), .ret_valid(ret_valid), .ret_arch(ret_arch),
    .ret_ptag(ret_ptag), .flush(flush)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  int m_frat [NA];
  int m_rrat [NA];
  bit m_free [NP];
  int last_accept = 0;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int lowest_free();
    for (int i = 0; i < NP; i++) if (m_free[i]) return i;
    return -1;
  endfunction

  task automatic step(input bit rv, input int s0, input int s1, input int d,
                      input bit tv, input int ta, input int tp, input bit fl);
    int lf, old;
    bit exp_ready;
    @(negedge clk);
    ren_valid = rv; ren_src0 = 3'(s0); ren_src1 = 3'(s1); ren_dst = 3'(d);
    ret_valid = tv; ret_arch = 3'(ta); ret_ptag = 7'(tp); flush = fl;
    #1;
    lf = lowest_free();
    exp_ready = (lf >= 0) && !fl;
    check(ren_ready == exp_ready, "R4 ready", int'(ren_ready), int'(exp_ready));
    if (s0 == d)
      check(int'(ren_psrc0) == m_frat[s0], "R3 src0 same as dst", int'(ren_psrc0), m_frat[s0]);
    else
      check(int'(ren_psrc0) == m_frat[s0], "R2 R5 src0", int'(ren_psrc0), m_frat[s0]);
    check(int'(ren_psrc1) == m_frat[s1], "R2 src1", int'(ren_psrc1), m_frat[s1]);
    check(int'(ren_pold) == m_frat[d], "R2 old dst", int'(ren_pold), m_frat[d]);
    if (exp_ready)
      check(int'(ren_pdst) == lf, "R2 lowest free", int'(ren_pdst), lf);
    last_accept = (rv && exp_ready) ? 1 : 0;
    if (tv) begin
      old = m_rrat[ta];
      m_rrat[ta] = tp;
      if (old != tp) m_free[old] = 1'b1;
    end
    if (fl) begin
      for (int i = 0; i < NP; i++) m_free[i] = 1'b1;
      for (int a = 0; a < NA; a++) begin
        m_frat[a] = m_rrat[a];
        m_free[m_rrat[a]] = 1'b0;
      end
    end else if (rv && exp_ready) begin
      m_frat[d] = lf;
      m_free[lf] = 1'b0;
    end
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    int old_tag, accepted;
    for (int a = 0; a < NA; a++) begin m_frat[a] = a; m_rrat[a] = a; end
    for (int i = 0; i < NP; i++) m_free[i] = (i >= NA);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: identity map and first allocation
    for (int i = 0; i < NA; i++) begin
      step(0, i, NA-1-i, i, 0, 0, 0, 0);
      check(int'(ren_psrc0) == i, "R1 reset map", int'(ren_psrc0), i);
    end
    check(int'(ren_pdst) == 8, "R1 first free", int'(ren_pdst), 8);

    // R2 R3: rename sweep with mixed operand patterns
    for (int r = 0; r < 40; r++) step(1, r % NA, (r*3) % NA, (r*5) % NA, 0, 0, 0, 0);
    for (int d = 0; d < NA; d++) step(1, d, d, d, 0, 0, 0, 0);

    // R5 R6: retire arch 3, displaced tag 3 becomes the next allocation
    step(0, 3, 3, 3, 1, 3, m_frat[3], 0);
    step(1, 3, 0, 1, 0, 0, 0, 0);
    check(m_frat[1] == 3, "R6 displaced tag reused", m_frat[1], 3);
    for (int a = 0; a < NA; a++) begin
      old_tag = m_rrat[a];
      step(1, a, (a+1) % NA, (a+2) % NA, 1, a, m_frat[a], 0);
    end
    // retire with the tag already committed frees nothing (R6)
    step(0, 0, 0, 0, 1, 2, m_rrat[2], 0);
    step(0, 0, 0, 0, 0, 0, 0, 0);

    // R7: flush restores committed table, rename during flush ignored (R4)
    for (int r = 0; r < 10; r++) step(1, r % NA, 0, (r*7) % NA, 0, 0, 0, 0);
    step(1, 0, 1, 2, 0, 0, 0, 1);
    for (int a = 0; a < NA; a++) begin
      step(0, a, a, a, 0, 0, 0, 0);
      check(int'(ren_psrc0) == m_rrat[a], "R7 table copy", int'(ren_psrc0), m_rrat[a]);
    end

    // R4 R7: drain the whole pool, count accepted renames
    accepted = 0;
    for (int r = 0; r < NP; r++) begin
      step(1, r % NA, (r+3) % NA, r % NA, 0, 0, 0, 0);
      accepted += last_accept;
    end
    check(accepted == NP - NA, "R7 pool size after flush", accepted, NP - NA);
    check(ren_ready == 1'b0, "R4 empty stall", int'(ren_ready), 0);
    step(1, 5, 6, 5, 0, 0, 0, 0);
    step(0, 5, 6, 5, 0, 0, 0, 0);
    check(int'(ren_pold) == m_frat[5], "R4 stalled rename ignored", int'(ren_pold), m_frat[5]);

    // R6: retire while empty frees one tag, which is offered next
    old_tag = m_rrat[4];
    step(0, 0, 0, 0, 1, 4, m_frat[4], 0);
    step(0, 0, 0, 0, 0, 0, 0, 0);
    check(ren_ready == 1'b1 && int'(ren_pdst) == old_tag, "R6 freed tag offered",
          int'(ren_pdst), old_tag);

    // R8: retire and flush in the same cycle
    step(0, 0, 0, 0, 1, 6, m_frat[6], 1);
    step(0, 6, 6, 6, 0, 0, 0, 0);
    check(int'(ren_psrc0) == m_rrat[6], "R8 flush sees retire", int'(ren_psrc0), m_rrat[6]);
    check(int'(ren_pdst) == lowest_free(), "R8 pool after flush", int'(ren_pdst), lowest_free());
    idle();

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule